// File: doc/BRIEF.md
# Biphase Edge-Tracking Data Recovery

This block sits at the front of a receiver for an AES3-style biphase-mark serial line. It runs from a system clock that is not related to the line. That clock oversamples the line by only a few cycles per unit interval (UI): about four at a 192 kHz frame rate with a 100 MHz clock. The input passes through a synchroniser, and every transition in either direction is flagged. The block times the gaps between transitions and turns them into one sampling strobe per UI. Each strobe carries the line level with it.

The spacing between strobes comes from a hold value. The hold value is the shortest gap between transitions seen over a window of edges. It is replaced whenever a window closes, so the block settles at 48, 96 and 192 kHz from the same clock. The hold value is never allowed below a floor set by a parameter. Without that floor, quantisation at the highest rate would shrink the value, a long three-UI preamble pulse would be sampled four times, and the downstream framer would fail to find its preambles. Downstream logic decodes the biphase symbols, recognises preambles and assembles frames from the strobed bits.

Top module: `bmc_edge_recovery`

## Requirements
- R1: `bit_o` holds the synchronised line level taken at the last strobe. Strobes that fall in successive line pulses therefore carry alternating levels.
- R2: While reset is high and in the cycle after it, `hold_o` equals 2^HOLD_W-1 (255 by default) and `valid_o` is low.
- R3: `valid_o` stays low until the first window of WINDOW_EDGES line transitions has completed.
- R4: When a window closes, `hold_o` takes the smallest gap between consecutive transitions seen in that window, counted in system clocks. This applies whether the line rate went up or down.
- R5: After the first window, `hold_o` is never below MIN_FLOOR (default 4). A line whose gaps are shorter reports MIN_FLOOR.
- R6: After each transition, the first strobe falls hold/2 clocks later, rounded down. Each further strobe falls hold clocks after the previous one, until the next transition restarts the timing.
- R7: With a 100 MHz clock at 48, 96 and 192 kHz frame rates, a pulse of one, two or three UI gets exactly one, two or three strobes. Run lengths of equal `bit_o` across strobes reproduce the sent pulse widths, including back-to-back three-UI preamble pulses.
- R8: `hold_o` changes only in the cycle after a window closes.
- R9: `valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the line |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous biphase-mark serial input |
| bit_o | output | 1 | Line level captured at the latest strobe |
| valid_o | output | 1 | One-cycle strobe, one per unit interval |
| hold_o | output | HOLD_W | Edge-gap value currently used for strobe placement |

## Verification
A hold value that is too small shows up as a fourth strobe inside a three-UI pulse. The preamble's run of three equal bits then breaks within a frame of lock. A value that is too large merges or drops strobes in one-UI pulses just as quickly. A window counter or minimum tracker that is wrong shows at `hold_o` one window after the fault: an unclamped value appears below the floor, or a value fails to follow a rate change across two windows. Strobes that are misplaced, doubled or come early before lock are visible directly on `valid_o` in the pulse where they happen.

// File: rtl/bmc_rx_pkg.sv
package bmc_rx_pkg;

  // Raise a measured edge gap to the configured floor.
  function automatic int unsigned floor_clamp(input int unsigned gap,
                                              input int unsigned lim);
    return (gap < lim) ? lim : gap;
  endfunction

endpackage

// File: rtl/bmc_line_sync.sv
module bmc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  // Any change of the synchronised level, rising or falling.
  assign edge_o  = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/bmc_gap_meter.sv
module bmc_gap_meter #(
  parameter int HOLD_W       = 8,
  parameter int WINDOW_EDGES = 1024,
  parameter int MIN_FLOOR    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_i,
  output logic [HOLD_W-1:0] hold_o,
  output logic              locked_o,
  output logic              win_done_o
);
  localparam logic [HOLD_W-1:0] HOLD_MAX = {HOLD_W{1'b1}};
  localparam int CNT_W = (WINDOW_EDGES > 2) ? $clog2(WINDOW_EDGES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW_EDGES - 1);

  logic [HOLD_W-1:0] run;
  logic [HOLD_W-1:0] win_min;
  logic [HOLD_W-1:0] cand_min;
  logic [CNT_W-1:0]  ecnt;

  // Clocks since the last transition, saturating.
  always_ff @(posedge clk) begin
    if (rst)                 run <= HOLD_MAX;
    else if (edge_i)         run <= HOLD_W'(1);
    else if (run != HOLD_MAX) run <= run + 1'b1;
  end

  always_comb begin
    cand_min = win_min;
    if (edge_i && (run < win_min)) cand_min = run;
  end

  assign win_done_o = edge_i && (ecnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt     <= '0;
      win_min  <= HOLD_MAX;
      hold_o   <= HOLD_MAX;
      locked_o <= 1'b0;
    end else if (win_done_o) begin
      ecnt     <= '0;
      win_min  <= HOLD_MAX;
      hold_o   <= HOLD_W'(bmc_rx_pkg::floor_clamp(int'(cand_min), MIN_FLOOR));
      locked_o <= 1'b1;
    end else if (edge_i) begin
      ecnt     <= ecnt + 1'b1;
      win_min  <= cand_min;
    end
  end
endmodule

// File: rtl/bmc_strobe_gen.sv
module bmc_strobe_gen #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_i,
  input  logic              level_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              enable_i,
  output logic              bit_o,
  output logic              valid_o
);
  logic [HOLD_W-1:0] tmr;
  logic              fire;

  assign fire = !edge_i && (tmr == HOLD_W'(1));

  always_ff @(posedge clk) begin
    if (rst)            tmr <= '0;
    else if (edge_i)    tmr <= hold_i >> 1;
    else if (fire)      tmr <= hold_i;
    else if (tmr != '0) tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      bit_o   <= 1'b0;
    end else begin
      valid_o <= fire && enable_i;
      if (fire) bit_o <= level_i;
    end
  end
endmodule

// File: rtl/bmc_edge_recovery.sv
module bmc_edge_recovery #(
  parameter int HOLD_W       = 8,
  parameter int WINDOW_EDGES = 1024,
  parameter int MIN_FLOOR    = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  output logic              bit_o,
  output logic              valid_o,
  output logic [HOLD_W-1:0] hold_o
);
  logic level;
  logic edge_seen;
  logic locked;
  logic win_done;

  bmc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_i(line_i),
    .level_o(level), .edge_o(edge_seen)
  );

  bmc_gap_meter #(
    .HOLD_W(HOLD_W), .WINDOW_EDGES(WINDOW_EDGES), .MIN_FLOOR(MIN_FLOOR)
  ) u_meter (
    .clk(clk), .rst(rst), .edge_i(edge_seen),
    .hold_o(hold_o), .locked_o(locked), .win_done_o(win_done)
  );

  bmc_strobe_gen #(.HOLD_W(HOLD_W)) u_strobe (
    .clk(clk), .rst(rst), .edge_i(edge_seen), .level_i(level),
    .hold_i(hold_o), .enable_i(locked),
    .bit_o(bit_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/bmc_edge_recovery_chk.sv
module bmc_edge_recovery_chk #(
  parameter int HOLD_W    = 8,
  parameter int MIN_FLOOR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              valid,
  input logic [HOLD_W-1:0] hold,
  input logic              locked,
  input logic              win_done
);
  localparam logic [HOLD_W-1:0] HOLD_MAX = {HOLD_W{1'b1}};

  p_reset_state_r2: assert property (@(posedge clk)
    rst |=> (hold == HOLD_MAX) && !valid);

  p_valid_needs_lock_r3: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !valid);

  p_hold_floor_r5: assert property (@(posedge clk) disable iff (rst)
    locked |-> (hold >= HOLD_W'(MIN_FLOOR)));

  p_hold_steady_r8: assert property (@(posedge clk) disable iff (rst)
    !win_done |=> $stable(hold));

  p_strobe_spaced_r9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

bind bmc_edge_recovery bmc_edge_recovery_chk #(
  .HOLD_W(HOLD_W), .MIN_FLOOR(MIN_FLOOR)
) u_chk (
  .clk(clk), .rst(rst), .valid(valid_o), .hold(hold_o),
  .locked(locked), .win_done(win_done)
);

// File: tb/bmc_edge_recovery_bench.sv
`timescale 1ns/1ps
module bmc_edge_recovery_bench;
  localparam int HOLD_W = 8;
  localparam int WIN    = 1024;
  localparam int FLOOR  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout;
  logic dv;
  logic [HOLD_W-1:0] hold;

  bmc_edge_recovery #(
    .HOLD_W(HOLD_W), .WINDOW_EDGES(WIN), .MIN_FLOOR(FLOOR), .SYNC_STAGES(2)
  ) u_bmc_edge_recovery (
    .clk(clk), .rst(rst), .line_i(din),
    .bit_o(dout), .valid_o(dv), .hold_o(hold)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // Pulse pattern in UI: two preamble pulses of 3 UI, then biphase data.
  int pat[128];
  int plen = 0;
  int pidx = 0;

  // Monitor state
  int  dv_total = 0;
  int  dv_double = 0;
  logic prev_dv = 1'b0;
  bit  mon_en = 1'b0;
  int  run_len = 0;
  logic last_lvl = 1'b0;
  int  runs[1024];
  int  nruns = 0;

  always @(negedge clk) begin
    if (dv) dv_total++;
    if (dv && prev_dv) dv_double++;
    prev_dv = dv;
    if (mon_en && dv) begin
      if (run_len > 0 && dout != last_lvl) begin
        if (nruns < 1024) runs[nruns] = run_len;
        nruns++;
        run_len = 1;
      end else begin
        run_len++;
      end
      last_lvl = dout;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_pat();
    plen = 0;
    pat[plen++] = 3; pat[plen++] = 3; pat[plen++] = 1; pat[plen++] = 1;
    for (int b = 0; b < 28; b++) begin
      if (((b * 5 + 3) % 7) < 3) begin
        pat[plen++] = 1; pat[plen++] = 1;
      end else begin
        pat[plen++] = 2;
      end
    end
  endtask

  task automatic drive_pulses(input real ui_ns, input int count);
    for (int i = 0; i < count; i++) begin
      #(ui_ns * pat[pidx]);
      din = ~din;
      pidx = (pidx + 1) % plen;
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din = 1'b0;
    pidx = 0;
    wait_clks(4);
    @(negedge clk);
    rst = 1'b0;
    #0.3;
  endtask

  task automatic check_runs(input string tag);
    int start = -1;
    int bad = 0;
    int n;
    for (int i = 0; i + 1 < nruns && i < 200; i++) begin
      if (runs[i] == 3 && runs[i+1] == 3) begin
        start = i;
        break;
      end
    end
    check(start >= 0, "R7", {tag, " double 3-UI preamble run found"}, start, 0);
    if (start >= 0) begin
      n = ((nruns < 1024) ? nruns : 1024) - start;
      for (int k = 0; k < n; k++)
        if (runs[start + k] != pat[k % plen]) bad++;
      // R1 alternating levels, R6 placement, R7 1/2/3 strobes per pulse
      check(bad == 0, "R7", {tag, " run lengths vs pulse widths (R1 R6)"}, bad, 0);
      check(n > 3 * plen, "R7", {tag, " runs observed"}, n, 3 * plen);
    end
  endtask

  task automatic test_reset_state();
    rst = 1'b1;
    wait_clks(3);
    @(negedge clk);
    check(hold == 8'd255, "R2", "hold after reset", hold, 255);
    check(dv == 1'b0, "R2", "valid after reset", dv, 0);
  endtask

  task automatic run_rate(input int fs, input int exp_hold, input string tag);
    real ui = 1.0e9 / (real'(fs) * 128.0);
    do_reset();
    dv_total = 0;
    dv_double = 0;
    drive_pulses(ui, 960);
    check(dv_total == 0, "R3", {tag, " strobes before first window"}, dv_total, 0);
    drive_pulses(ui, 240);
    wait_clks(10);
    @(negedge clk);
    check(int'(hold) == exp_hold, "R4", {tag, " hold after lock"}, hold, exp_hold);
    nruns = 0; run_len = 0; mon_en = 1'b1;
    drive_pulses(ui, 400);
    mon_en = 1'b0;
    check_runs(tag);
    check(dv_double == 0, "R9", {tag, " back-to-back strobes"}, dv_double, 0);
  endtask

  task automatic test_switch();
    real ui48  = 1.0e9 / (48000.0 * 128.0);
    real ui192 = 1.0e9 / (192000.0 * 128.0);
    // Line is locked at 48 kHz from the previous scenario.
    drive_pulses(ui192, 1200);
    wait_clks(10);
    @(negedge clk);
    check(hold == 8'd4, "R4", "hold follows rate up", hold, 4);
    drive_pulses(ui48, 2200);
    wait_clks(10);
    @(negedge clk);
    check(hold == 8'd16, "R4", "hold follows rate down", hold, 16);
  endtask

  task automatic test_clamp();
    do_reset();
    for (int i = 0; i < 1100; i++) begin
      #30;
      din = ~din;
    end
    wait_clks(10);
    @(negedge clk);
    check(hold == 8'(FLOOR), "R5", "hold clamped on 3-clock gaps", hold, FLOOR);
  endtask

  initial begin
    build_pat();
    test_reset_state();
    run_rate(48000, 16, "48k");
    test_switch();
    run_rate(96000, 8, "96k");
    run_rate(192000, 4, "192k");
    test_clamp();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_950_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule